// File: doc/BRIEF.md
# Extended CRTC Index Register Bank

This block is an indexed register bank that sits next to a standard display timing controller. The host loads an index register and then reads or writes through a data port. Low indices (0x00 to 0x18) are forwarded unchanged to the standard controller's register interface. Higher indices are decoded here: fixed identification values, an unlock key, a read/write memory bank selector, extension bits for the display start address, and overflow bits that widen the horizontal and vertical timing fields.

Writes to the bank-select register at 0x35 are accepted only while the key register holds a valid unlock pattern. A one-cycle mode-change pulse tells the downstream timing generator to recompute its parameters whenever a register that affects timing or pixel format is written. Any index not given a special meaning simply stores its byte and returns it on read.

Top module: `xcrtc_regbank`

## Requirements
- R1: A data write while the index is 0x18 or lower asserts `std_wr` in the same cycle with `std_index` equal to the index and `std_wdata` equal to the data, and a read at such an index returns `std_rdata`; a data write at an index above 0x18 never asserts `std_wr`.
- R2: Reads of index 0x2D, 0x2E, 0x2F and 0x30 return 0x56, 0x31, 0x00 and 0xE1, whatever has been written to them.
- R3: A write to 0x35 is accepted only when the last byte written to 0x38 has bits [3:2] equal to 2'b10 and bits [7:6] not 2'b00; an accepted write sets both banks to {2'b00, data[3:0]} and becomes the readback of 0x35, while a rejected write changes neither the banks nor that readback.
- R4: A write to 0x6A sets both banks to data[5:0]; reading 0x6A returns {2'b00, bank}. The two bank outputs are always equal.
- R5: A write to 0x51 sets start-extension bits [3:2] (address bits 19:18) from data[1:0] and bank bits [5:4] from data[3:2], leaving the other bank bits; reading 0x51 returns {4'b0000, bank[5:4], start_ext[3:2]}.
- R6: A write to 0x31 sets start_ext[1:0] (address bits 17:16) from data[5:4] and reads back the full byte; a write to 0x69 sets start_ext[4:0] (address bits 20:16) from data[4:0] and 0x69 reads back {3'b000, start_ext}.
- R7: A write to 0x5D sets hext[0]=d[0] (total bit 8), hext[1]=d[1] (display end bit 8), hext[2]=d[2] (blank start bit 8), hext[3]=d[4] (retrace start bit 8), hext[4]=d[3] (blank end bit 6), hext[5]=d[5] (retrace end bit 5).
- R8: A write to 0x5E sets vext[0]=d[0] (total), vext[1]=d[1] (display end), vext[2]=d[2] (blank start), vext[3]=d[4] (retrace start), vext[4]=d[6] (line compare), each being bit 10 of its field; other writes leave vext unchanged.
- R9: Reading index 0x42 returns only the low nibble of the byte last written there, upper nibble zero.
- R10: Every other index above 0x18 (including 0x38, 0x5D, 0x5E, 0x67) stores the written byte and reads it back unchanged.
- R11: `mode_chg` is high for exactly the cycle after a write to 0x31, 0x51, 0x5D, 0x5E, 0x67 or 0x69, and low after any other cycle.
- R12: After reset both banks, start_ext, hext, vext and mode_chg are zero, and every locally stored byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load index register |
| idx_in | input | 8 | Index value |
| dat_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Data-port write byte |
| rdata | output | 8 | Data-port read byte for current index |
| std_wr | output | 1 | Write strobe to standard controller |
| std_index | output | 5 | Register index to standard controller |
| std_wdata | output | 8 | Write byte to standard controller |
| std_rdata | input | 8 | Read byte from standard controller |
| bank_rd | output | 6 | Read memory bank |
| bank_wr | output | 6 | Write memory bank |
| start_ext | output | 5 | Display start address bits 20:16 |
| hext | output | 6 | Horizontal overflow bits |
| vext | output | 5 | Vertical overflow bits |
| mode_chg | output | 1 | One-cycle mode recompute pulse |

## Verification
An index load is visible on `rdata` from the cycle after the `idx_wr` edge, and reads are combinational from then on, so the bench checks them one time unit after the following falling edge. `std_wr`, `std_index` and `std_wdata` follow a data write within the same cycle and are checked before the rising edge that takes the write. Banks, start extension, overflow bits and `mode_chg` change on the edge that samples `dat_wr`, so they are checked just after the next falling edge, and `mode_chg` is checked low again one cycle later when no write follows.

// File: rtl/xcrtc_pkg.sv
`timescale 1ns/1ps
package xcrtc_pkg;
  localparam int XC_DW       = 8;
  localparam int XC_IW       = 8;
  localparam int XC_STD_LAST = 24;
  localparam int XC_BANK_W   = 6;
  localparam int XC_SEXT_W   = 5;
  localparam int XC_HEXT_W   = 6;
  localparam int XC_VEXT_W   = 5;

  localparam logic [7:0] IX_ID_HI   = 8'h2D;
  localparam logic [7:0] IX_ID_LO   = 8'h2E;
  localparam logic [7:0] IX_REV     = 8'h2F;
  localparam logic [7:0] IX_ID_CHIP = 8'h30;
  localparam logic [7:0] IX_MEMCFG  = 8'h31;
  localparam logic [7:0] IX_WINDOW  = 8'h35;
  localparam logic [7:0] IX_KEY     = 8'h38;
  localparam logic [7:0] IX_CLKSEL  = 8'h42;
  localparam logic [7:0] IX_HIBITS  = 8'h51;
  localparam logic [7:0] IX_HOVF    = 8'h5D;
  localparam logic [7:0] IX_VOVF    = 8'h5E;
  localparam logic [7:0] IX_FMT     = 8'h67;
  localparam logic [7:0] IX_SADDR   = 8'h69;
  localparam logic [7:0] IX_BANK    = 8'h6A;

  localparam logic [7:0] ID_HI_VAL   = 8'h56;
  localparam logic [7:0] ID_LO_VAL   = 8'h31;
  localparam logic [7:0] REV_VAL     = 8'h00;
  localparam logic [7:0] CHIP_ID_VAL = 8'hE1;

  // key holds {data[7:6], data[3:2]} of the last write to the key index
  function automatic logic key_open(input logic [3:0] k);
    return (k[1:0] == 2'b10) && (k[3:2] != 2'b00);
  endfunction
endpackage

// File: rtl/xcrtc_scratch.sv
`timescale 1ns/1ps
module xcrtc_scratch #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

  // R10: a stored byte is present at its address after the write edge
  p_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/xcrtc_window.sv
`timescale 1ns/1ps
module xcrtc_window
  import xcrtc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 6,
  parameter int SEXT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     wdata,
  input  logic              wr_key,
  input  logic              wr_win,
  input  logic              wr_bank,
  input  logic              wr_hib,
  input  logic              wr_mcfg,
  input  logic              wr_sx,
  output logic [BANK_W-1:0] bank_rd,
  output logic [BANK_W-1:0] bank_wr,
  output logic [SEXT_W-1:0] start_ext,
  output logic [DW-1:0]     win_rb
);
  logic [3:0]        key_q, key_d;
  logic [BANK_W-1:0] bankw_q, bankw_d, bankr_q, bankr_d;
  logic [SEXT_W-1:0] sext_q, sext_d;
  logic [DW-1:0]     win_q, win_d;
  logic              accept, bank_en, sext_en;

  always_comb begin
    accept  = wr_win && key_open(key_q);
    bank_en = accept || wr_bank || wr_hib;
    sext_en = wr_mcfg || wr_hib || wr_sx;

    key_d = key_q;
    if (wr_key) key_d = {wdata[7:6], wdata[3:2]};

    bankw_d = bankw_q;
    if (accept)  bankw_d = BANK_W'(wdata[3:0]);
    if (wr_bank) bankw_d = wdata[BANK_W-1:0];
    if (wr_hib)  bankw_d[5:4] = wdata[3:2];
    bankr_d = bank_en ? bankw_d : bankr_q;

    win_d = accept ? wdata : win_q;

    sext_d = sext_q;
    if (wr_mcfg) sext_d[1:0] = wdata[5:4];
    if (wr_hib)  sext_d[3:2] = wdata[1:0];
    if (wr_sx)   sext_d      = wdata[SEXT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      bankw_q <= '0;
      bankr_q <= '0;
      sext_q  <= '0;
      win_q   <= '0;
    end else begin
      if (wr_key)  key_q   <= key_d;
      if (bank_en) bankw_q <= bankw_d;
      if (bank_en) bankr_q <= bankr_d;
      if (sext_en) sext_q  <= sext_d;
      if (accept)  win_q   <= win_d;
    end
  end

  assign bank_rd   = bankr_q;
  assign bank_wr   = bankw_q;
  assign start_ext = sext_q;
  assign win_rb    = win_q;

  // R3: a locked window write leaves banks and readback untouched
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && !key_open(key_q)) |=> ($stable(bankw_q) && $stable(win_q)));

  // R4: read and write banks never diverge
  p_bank_twin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bankr_q == bankw_q);

  // R6: full start-extension load
  p_sext_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sx |=> (sext_q == $past(wdata[SEXT_W-1:0])));

  // R5: bank high-bits load keeps the low bank bits
  p_hib_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hib |=> (bankw_q[3:0] == $past(bankw_q[3:0])));
endmodule

// File: rtl/xcrtc_overflow.sv
`timescale 1ns/1ps
module xcrtc_overflow #(
  parameter int HEXT_W = 6,
  parameter int VEXT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        wdata,
  input  logic              wr_h,
  input  logic              wr_v,
  output logic [HEXT_W-1:0] hext,
  output logic [VEXT_W-1:0] vext
);
  logic [HEXT_W-1:0] hext_q, hext_d;
  logic [VEXT_W-1:0] vext_q, vext_d;

  always_comb begin
    hext_d = hext_q;
    vext_d = vext_q;
    if (wr_h) hext_d = {wdata[5], wdata[3], wdata[4], wdata[2], wdata[1], wdata[0]};
    if (wr_v) vext_d = {wdata[6], wdata[4], wdata[2], wdata[1], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hext_q <= '0;
      vext_q <= '0;
    end else begin
      if (wr_h) hext_q <= hext_d;
      if (wr_v) vext_q <= vext_d;
    end
  end

  assign hext = hext_q;
  assign vext = vext_q;

  // R7: blank-end and retrace-start bits cross over
  p_hmap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_h |=> ((hext_q[4] == $past(wdata[3])) && (hext_q[3] == $past(wdata[4]))));

  // R8: vertical bits move only on their own write
  p_vkeep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_v |=> $stable(vext_q));
endmodule

// File: rtl/xcrtc_regbank.sv
`timescale 1ns/1ps
module xcrtc_regbank
  import xcrtc_pkg::*;
#(
  parameter int DW       = XC_DW,
  parameter int IW       = XC_IW,
  parameter int STD_LAST = XC_STD_LAST,
  parameter int BANK_W   = XC_BANK_W,
  parameter int SEXT_W   = XC_SEXT_W,
  parameter int HEXT_W   = XC_HEXT_W,
  parameter int VEXT_W   = XC_VEXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [IW-1:0]     idx_in,
  input  logic              dat_wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              std_wr,
  output logic [4:0]        std_index,
  output logic [DW-1:0]     std_wdata,
  input  logic [DW-1:0]     std_rdata,
  output logic [BANK_W-1:0] bank_rd,
  output logic [BANK_W-1:0] bank_wr,
  output logic [SEXT_W-1:0] start_ext,
  output logic [HEXT_W-1:0] hext,
  output logic [VEXT_W-1:0] vext,
  output logic              mode_chg
);
  localparam int STD_IW = $clog2(STD_LAST + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [IW-1:0] idx_q, idx_d;
  logic          is_std, wr_loc;
  logic          mode_q, mode_d;
  logic [DW-1:0] scr_rd, win_rb;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_comb begin
    idx_d  = idx_wr ? idx_in : idx_q;
    is_std = (idx_q <= IW'(STD_LAST));
    wr_loc = dat_wr && !is_std;
    mode_d = wr_loc && ((idx_q == IX_MEMCFG) || (idx_q == IX_HIBITS) ||
                        (idx_q == IX_HOVF)   || (idx_q == IX_VOVF)   ||
                        (idx_q == IX_FMT)    || (idx_q == IX_SADDR));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= idx_d;
      mode_q <= mode_d;
    end
  end

  assign std_wr    = dat_wr && is_std;
  assign std_index = idx_q[STD_IW-1:0];
  assign std_wdata = wdata;
  assign mode_chg  = mode_q;

  xcrtc_scratch #(.DW(DW), .IW(IW)) u_scratch (
    .clk   (clk),
    .rst_n (rst_ni),
    .we    (wr_loc),
    .addr  (idx_q),
    .wdata (wdata),
    .rdata (scr_rd)
  );

  xcrtc_window #(.DW(DW), .BANK_W(BANK_W), .SEXT_W(SEXT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wdata     (wdata),
    .wr_key    (wr_loc && (idx_q == IX_KEY)),
    .wr_win    (wr_loc && (idx_q == IX_WINDOW)),
    .wr_bank   (wr_loc && (idx_q == IX_BANK)),
    .wr_hib    (wr_loc && (idx_q == IX_HIBITS)),
    .wr_mcfg   (wr_loc && (idx_q == IX_MEMCFG)),
    .wr_sx     (wr_loc && (idx_q == IX_SADDR)),
    .bank_rd   (bank_rd),
    .bank_wr   (bank_wr),
    .start_ext (start_ext),
    .win_rb    (win_rb)
  );

  xcrtc_overflow #(.HEXT_W(HEXT_W), .VEXT_W(VEXT_W)) u_overflow (
    .clk   (clk),
    .rst_n (rst_ni),
    .wdata (wdata[6:0]),
    .wr_h  (wr_loc && (idx_q == IX_HOVF)),
    .wr_v  (wr_loc && (idx_q == IX_VOVF)),
    .hext  (hext),
    .vext  (vext)
  );

  always_comb begin
    if (is_std) begin
      rdata = std_rdata;
    end else begin
      case (idx_q)
        IX_ID_HI:   rdata = ID_HI_VAL;
        IX_ID_LO:   rdata = ID_LO_VAL;
        IX_REV:     rdata = REV_VAL;
        IX_ID_CHIP: rdata = CHIP_ID_VAL;
        IX_WINDOW:  rdata = win_rb;
        IX_CLKSEL:  rdata = DW'(scr_rd[3:0]);
        IX_HIBITS:  rdata = DW'({bank_wr[5:4], start_ext[3:2]});
        IX_SADDR:   rdata = DW'(start_ext);
        IX_BANK:    rdata = DW'(bank_rd);
        default:    rdata = scr_rd;
      endcase
    end
  end

  // R1: a write at a high index never reaches the standard controller
  p_std_iso_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_wr && (idx_q > IW'(STD_LAST))) |-> !std_wr);

  // R11: format register write raises the pulse next cycle
  p_mode_fmt_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_wr && (idx_q == IX_FMT)) |=> mode_chg);

  // R11: no write, no pulse
  p_mode_quiet_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !dat_wr |=> !mode_chg);
endmodule

// File: tb/xcrtc_regbank_bench.sv
`timescale 1ns/1ps
module xcrtc_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       idx_wr, dat_wr;
  logic [7:0] idx_in, wdata, rdata, std_wdata, std_rdata;
  logic       std_wr, mode_chg;
  logic [4:0] std_index, start_ext, vext;
  logic [5:0] bank_rd, bank_wr, hext;

  int vectors = 0;
  int fails   = 0;

  logic [7:0] std_regs [32];
  logic [7:0] m_mem [256];
  logic [7:0] m_std [32];
  logic [5:0] m_bank, m_hext;
  logic [4:0] m_sext, m_vext;
  logic [7:0] m_win;
  logic [7:0] cur;
  logic       m_mode;

  always #10 clk = ~clk;

  xcrtc_regbank u_xcrtc_regbank (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_in(idx_in),
    .dat_wr(dat_wr), .wdata(wdata), .rdata(rdata),
    .std_wr(std_wr), .std_index(std_index), .std_wdata(std_wdata),
    .std_rdata(std_rdata), .bank_rd(bank_rd), .bank_wr(bank_wr),
    .start_ext(start_ext), .hext(hext), .vext(vext), .mode_chg(mode_chg)
  );

  // stand-in for the standard controller
  always @(posedge clk) if (std_wr) std_regs[std_index] <= std_wdata;
  assign std_rdata = std_regs[std_index];

  function automatic logic key_ok(input logic [7:0] k);
    return (k[3:2] == 2'b10) && (k[7:6] != 2'b00);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] i);
    if (i <= 8'h18) return m_std[i[4:0]];
    case (i)
      8'h2D: return 8'h56;
      8'h2E: return 8'h31;
      8'h2F: return 8'h00;
      8'h30: return 8'hE1;
      8'h35: return m_win;
      8'h42: return {4'h0, m_mem[i][3:0]};
      8'h51: return {4'h0, m_bank[5:4], m_sext[3:2]};
      8'h69: return {3'b000, m_sext};
      8'h6A: return {2'b00, m_bank};
      default: return m_mem[i];
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] i);
    if (i <= 8'h18) return "R1 std read";
    case (i)
      8'h2D, 8'h2E, 8'h2F, 8'h30: return "R2 id";
      8'h35: return "R3 window rb";
      8'h6A: return "R4 bank rb";
      8'h51: return "R5 hibits rb";
      8'h31, 8'h69: return "R6 start rb";
      8'h42: return "R9 nibble rb";
      default: return "R10 store rb";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic set_idx(input logic [7:0] i);
    idx_wr = 1'b1; idx_in = i;
    @(negedge clk);
    idx_wr = 1'b0;
    cur = i;
  endtask

  task automatic rd();
    #1 chk(rd_tag(cur), rdata, exp_rd(cur));
    @(negedge clk);
    #1 chk("R11 mode idle", mode_chg, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    logic acc;
    dat_wr = 1'b1; wdata = d;
    #1;
    if (cur <= 8'h18) begin
      chk("R1 std_wr", std_wr, 1'b1);
      chk("R1 std_index", std_index, cur[4:0]);
      chk("R1 std_wdata", std_wdata, d);
    end else begin
      chk("R1 std_wr quiet", std_wr, 1'b0);
    end
    @(negedge clk);
    dat_wr = 1'b0;
    m_mode = 1'b0;
    if (cur <= 8'h18) begin
      m_std[cur[4:0]] = d;
    end else begin
      acc = (cur == 8'h35) && key_ok(m_mem[8'h38]);
      m_mem[cur] = d;
      case (cur)
        8'h31: m_sext[1:0] = d[5:4];
        8'h35: if (acc) begin m_bank = {2'b00, d[3:0]}; m_win = d; end
        8'h51: begin m_sext[3:2] = d[1:0]; m_bank[5:4] = d[3:2]; end
        8'h5D: m_hext = {d[5], d[3], d[4], d[2], d[1], d[0]};
        8'h5E: m_vext = {d[6], d[4], d[2], d[1], d[0]};
        8'h69: m_sext = d[4:0];
        8'h6A: m_bank = d[5:0];
        default: ;
      endcase
      m_mode = (cur == 8'h31) || (cur == 8'h51) || (cur == 8'h5D) ||
               (cur == 8'h5E) || (cur == 8'h67) || (cur == 8'h69);
    end
    #1;
    chk("R11 mode pulse", mode_chg, m_mode);
    chk("R3/R4 bank_wr", bank_wr, m_bank);
    chk("R4 bank_rd", bank_rd, m_bank);
    chk("R6 start_ext", start_ext, m_sext);
    chk("R7 hext", hext, m_hext);
    chk("R8 vext", vext, m_vext);
  endtask

  task automatic wr_at(input logic [7:0] i, input logic [7:0] d);
    set_idx(i); wr(d);
  endtask

  task automatic rd_at(input logic [7:0] i);
    set_idx(i); rd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] pool [16];
    int unsigned seed;
    pool = '{8'h05, 8'h18, 8'h19, 8'h2D, 8'h30, 8'h31, 8'h35, 8'h38,
             8'h42, 8'h51, 8'h5D, 8'h5E, 8'h67, 8'h69, 8'h6A, 8'h90};
    for (int i = 0; i < 32; i++) begin std_regs[i] = 8'h00; m_std[i] = 8'h00; end
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_bank = '0; m_sext = '0; m_hext = '0; m_vext = '0; m_win = '0; m_mode = 1'b0;
    cur = 8'h00;
    idx_wr = 1'b0; dat_wr = 1'b0; idx_in = 8'h00; wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    #1;
    chk("R12 bank_rd", bank_rd, 6'd0);
    chk("R12 bank_wr", bank_wr, 6'd0);
    chk("R12 start_ext", start_ext, 5'd0);
    chk("R12 hext", hext, 6'd0);
    chk("R12 vext", vext, 5'd0);
    chk("R12 mode", mode_chg, 1'b0);
    rd_at(8'h77);
    rd_at(8'h2D); rd_at(8'h2E); rd_at(8'h2F); rd_at(8'h30);

    // R2 identification ignores writes
    wr_at(8'h2D, 8'hAA); rd();
    wr_at(8'h30, 8'h00); rd();

    // R3 lock behaviour
    wr_at(8'h35, 8'h0F); rd();          // key zero: rejected
    wr_at(8'h38, 8'h48); rd();          // open key
    wr_at(8'h35, 8'h3B); rd();          // accepted, bank 0x0B
    chk("R3 accepted bank", bank_wr, 6'h0B);
    wr_at(8'h38, 8'h08);                // [7:6]=0 closes
    wr_at(8'h35, 8'h05); rd();
    chk("R3 rejected bank", bank_wr, 6'h0B);
    wr_at(8'h38, 8'hC4);                // [3:2]=01 closes
    wr_at(8'h35, 8'h06); rd();
    chk("R3 rejected bank2", bank_rd, 6'h0B);
    wr_at(8'h38, 8'h88);
    wr_at(8'h35, 8'h05); rd();
    chk("R3 reopened bank", bank_rd, 6'h05);

    // R4, R5, R6
    wr_at(8'h6A, 8'hFF); rd();
    wr_at(8'h51, 8'h0E); rd();
    wr_at(8'h31, 8'hFF); rd();
    wr_at(8'h69, 8'hEA); rd();
    chk("R6 start_ext 0x69", start_ext, 5'h0A);

    // R7, R8, R9, R10, R11, R1
    wr_at(8'h5D, 8'h08); chk("R7 blank end", hext, 6'b010000);
    wr_at(8'h5D, 8'h10); chk("R7 retrace start", hext, 6'b001000);
    wr_at(8'h5E, 8'h40); chk("R8 line compare", vext, 5'b10000);
    wr_at(8'h42, 8'hA7); rd();
    wr_at(8'h80, 8'h5C); rd();
    wr_at(8'h67, 8'h30); rd();
    wr_at(8'h18, 8'h77); rd();
    wr_at(8'h19, 8'h33); rd();

    // constrained random mix
    seed = 32'd1234;
    void'($urandom(seed));
    for (int n = 0; n < 800; n++) begin
      logic [7:0] ix, dv;
      ix = ($urandom % 5 == 0) ? 8'($urandom) : pool[$urandom % 16];
      dv = 8'($urandom);
      set_idx(ix);
      if ($urandom % 2 == 0) wr(dv);
      rd();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule